// File: doc/BRIEF.md
# Paged SERDES Register Access Sequencer

This block lets a requester read and write control registers that sit inside a SERDES PHY. The registers cannot be reached directly. They sit behind a small memory-mapped window that shows one 512-register page at a time. The block also uses an indirect command interface made of three registers: control, address and data. The requester supplies a 16-bit target register address, a 5-bit PHY device id, a write flag and, for writes, the write data. The block runs the whole indirect sequence on its own. It returns a one-cycle completion pulse and, for reads, the register value.

Every step of the sequence is one window access. A window access is a page-register write followed, with nothing in between, by the data access at the computed word offset. Before the block touches the indirect address or data registers, it polls the busy bit of the indirect control register. While that bit is set, it leaves the bus idle for a programmable number of cycles between polls.

Top module: `sdx_paged_seq`

## Requirements
- R1: Every data access to the window is directly preceded by a write to window offset 0x800. The value written is the device id times 128 plus bits 15:9 of the indirect register being reached, so bits 6:0 are always 0x40. No other access comes in between.
- R2: The window offset of a data access is bits 8:0 of the indirect register address times 4. The control register (0x80a0) maps to offset 0x280, the address register (0x80a1) to 0x284 and the data register (0x80a2) to 0x288.
- R3: A read runs these steps in order: poll control until bit 0 is clear, write the target address to the address register, write 0x0001 to control, poll control until bit 0 is clear, read the data register. No step reaches the address or data register while the PHY is busy.
- R4: A write runs these steps in order: poll control until bit 0 is clear, write the target address, write the data register, write 0x0003 to control. The block does not wait for completion after that last step.
- R5: A poll that returns bit 0 set is repeated. At least POLL_CYCLES clock cycles with no bus request pass before the next page write.
- R6: rsp_done is high for exactly one cycle when a sequence ends. For a read, rsp_rdata then equals the value of the target register.
- R7: req_ready is low from the cycle after a request is accepted until the sequence ends. A request presented while it is low is ignored and starts no bus activity. A request presented in the same cycle as rsp_done is accepted.
- R8: After reset, req_ready is 1 and bus_req, bus_we, rsp_done and rsp_rdata are 0.
- R9: While bus_req is high and bus_ready is low, bus_req, bus_addr, bus_we and bus_wdata hold their values.
- R10: rsp_rdata changes only in a cycle in which rsp_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = write sequence, 0 = read sequence |
| req_addr | input | 16 | Target PHY register address |
| req_dev | input | 5 | PHY device id used for the page value |
| req_wdata | input | 16 | Write data for the target register |
| req_ready | output | 1 | Block idle, able to take a request |
| rsp_done | output | 1 | One-cycle end-of-sequence pulse |
| rsp_rdata | output | 16 | Value returned by the last read |
| bus_req | output | 1 | Window access request |
| bus_we | output | 1 | Window access is a write |
| bus_addr | output | 12 | Window byte offset |
| bus_wdata | output | 16 | Window write data |
| bus_rdata | input | 16 | Window read data, taken with bus_ready |
| bus_ready | input | 1 | Window access completes on this clock edge |

## Verification
Two events can land in the same cycle. The first is the end-of-sequence pulse and a new request: the bench drives the next request in exactly the cycle where rsp_done is seen, and expects it to be taken and the next bus sequence to follow. The second is the arrival of a request while the sequence is still running. The bench drives a conflicting request in the middle of a sequence and judges from the logged bus traffic that only the original sequence ran. The window model stretches the busy flag after every start command, so that back-to-back operations find it still set. The bench then measures the idle gap before the repeated poll.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int REG_AW = 16;
  localparam int DEV_W  = 5;
  localparam int WIN_AW = 12;
  localparam int PG_LSB = 9;

  localparam logic [REG_AW-1:0] IREG_CTL = 16'h80a0;
  localparam logic [REG_AW-1:0] IREG_ADR = 16'h80a1;
  localparam logic [REG_AW-1:0] IREG_DAT = 16'h80a2;
  localparam logic [WIN_AW-1:0] PAGE_SLOT = 12'h800;
  localparam logic [15:0] CTL_GO    = 16'h0001;
  localparam logic [15:0] CTL_GO_WR = 16'h0003;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_A, ST_LOAD_ADR, ST_LOAD_DAT, ST_KICK, ST_POLL_B, ST_FETCH
  } step_e;

  // page register value: device id above the upper address bits
  function automatic logic [DEV_W+REG_AW-PG_LSB-1:0] page_word(
      input logic [DEV_W-1:0] dev, input logic [REG_AW-1:0] a);
    return {dev, a[REG_AW-1:PG_LSB]};
  endfunction

  // byte offset of a register inside the window
  function automatic logic [WIN_AW-1:0] slot_of(input logic [REG_AW-1:0] a);
    return WIN_AW'({a[PG_LSB-1:0], 2'b00});
  endfunction

  function automatic step_e step_after(input step_e s, input logic wr);
    case (s)
      ST_POLL_A:   return ST_LOAD_ADR;
      ST_LOAD_ADR: return wr ? ST_LOAD_DAT : ST_KICK;
      ST_LOAD_DAT: return ST_KICK;
      ST_KICK:     return wr ? ST_IDLE : ST_POLL_B;
      ST_POLL_B:   return ST_FETCH;
      default:     return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/sdx_gap_timer.sv
module sdx_gap_timer #(
  parameter int CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic gap_busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (arm)            cnt <= CW'(CYC);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign gap_busy = (cnt != '0);
endmodule

// File: rtl/sdx_win_port.sv
module sdx_win_port
  import sdx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_we,
  input  logic [REG_AW-1:0] acc_reg,
  input  logic [DEV_W-1:0]  acc_dev,
  input  logic [DW-1:0]     acc_wdata,
  output logic              acc_done,
  output logic [DW-1:0]     acc_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WIN_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready,
  output logic              page_phase,
  output logic              data_phase
);
  typedef enum logic [1:0] {W_IDLE, W_PAGE, W_DATA} wst_e;
  wst_e st;
  logic              l_we;
  logic [REG_AW-1:0] l_reg;
  logic [DEV_W-1:0]  l_dev;
  logic [DW-1:0]     l_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
      l_we      <= 1'b0;
      l_reg     <= '0;
      l_dev     <= '0;
      l_wdata   <= '0;
    end else begin
      acc_done <= 1'b0;
      case (st)
        W_IDLE: if (acc_start) begin
          l_we    <= acc_we;
          l_reg   <= acc_reg;
          l_dev   <= acc_dev;
          l_wdata <= acc_wdata;
          st      <= W_PAGE;
        end
        W_PAGE: if (bus_ready) st <= W_DATA;
        W_DATA: if (bus_ready) begin
          st       <= W_IDLE;
          acc_done <= 1'b1;
          if (!l_we) acc_rdata <= bus_rdata;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign page_phase = (st == W_PAGE);
  assign data_phase = (st == W_DATA);

  always_comb begin
    bus_req   = page_phase || data_phase;
    bus_we    = page_phase || (data_phase && l_we);
    bus_addr  = '0;
    bus_wdata = '0;
    if (page_phase) begin
      bus_addr  = PAGE_SLOT;
      bus_wdata = DW'(page_word(l_dev, l_reg));
    end else if (data_phase) begin
      bus_addr  = slot_of(l_reg);
      bus_wdata = l_we ? l_wdata : '0;
    end
  end
endmodule

// File: rtl/sdx_step_fsm.sv
module sdx_step_fsm
  import sdx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DW-1:0]     req_wdata,
  output logic              seq_idle,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  output logic              acc_start,
  output logic              acc_we,
  output logic [REG_AW-1:0] acc_reg,
  output logic [DEV_W-1:0]  acc_dev,
  output logic [DW-1:0]     acc_wdata,
  input  logic              acc_done,
  input  logic [DW-1:0]     acc_rdata,
  input  logic              gap_busy,
  output logic              gap_arm
);
  step_e             step;
  logic              issued;
  logic              t_write;
  logic [REG_AW-1:0] t_addr;
  logic [DEV_W-1:0]  t_dev;
  logic [DW-1:0]     t_wdata;
  logic              is_poll;
  step_e             nxt;

  assign seq_idle = (step == ST_IDLE);
  assign is_poll  = (step == ST_POLL_A) || (step == ST_POLL_B);
  assign gap_arm  = is_poll && acc_done && acc_rdata[0];
  assign nxt      = step_after(step, t_write);
  assign acc_dev  = t_dev;

  always_comb begin
    acc_start = !seq_idle && !issued && !gap_busy;
    acc_reg   = IREG_CTL;
    acc_we    = 1'b0;
    acc_wdata = '0;
    case (step)
      ST_LOAD_ADR: begin acc_reg = IREG_ADR; acc_we = 1'b1; acc_wdata = DW'(t_addr); end
      ST_LOAD_DAT: begin acc_reg = IREG_DAT; acc_we = 1'b1; acc_wdata = t_wdata; end
      ST_KICK:     begin acc_we = 1'b1; acc_wdata = DW'(t_write ? CTL_GO_WR : CTL_GO); end
      ST_FETCH:    acc_reg = IREG_DAT;
      default:     ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step      <= ST_IDLE;
      issued    <= 1'b0;
      t_write   <= 1'b0;
      t_addr    <= '0;
      t_dev     <= '0;
      t_wdata   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (seq_idle) begin
        if (req_valid) begin
          t_write <= req_write;
          t_addr  <= req_addr;
          t_dev   <= req_dev;
          t_wdata <= req_wdata;
          issued  <= 1'b0;
          step    <= ST_POLL_A;
        end
      end else begin
        if (acc_start) issued <= 1'b1;
        if (acc_done) begin
          issued <= 1'b0;
          if (!gap_arm) begin
            step <= nxt;
            if (nxt == ST_IDLE) rsp_done <= 1'b1;
            if (step == ST_FETCH) rsp_rdata <= acc_rdata;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdx_paged_seq.sv
module sdx_paged_seq
  import sdx_pkg::*;
#(
  parameter int DW          = 16,
  parameter int POLL_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [REG_AW-1:0] req_addr,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DW-1:0]     rsp_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [WIN_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  logic              acc_start, acc_we, acc_done;
  logic [REG_AW-1:0] acc_reg;
  logic [DEV_W-1:0]  acc_dev;
  logic [DW-1:0]     acc_wdata, acc_rdata;
  logic              gap_arm, gap_busy;
  logic              page_phase, data_phase;

  sdx_step_fsm #(.DW(DW)) u_steps (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_dev(req_dev), .req_wdata(req_wdata),
    .seq_idle(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .acc_start(acc_start), .acc_we(acc_we), .acc_reg(acc_reg),
    .acc_dev(acc_dev), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .acc_rdata(acc_rdata),
    .gap_busy(gap_busy), .gap_arm(gap_arm)
  );

  sdx_win_port #(.DW(DW)) u_win (
    .clk(clk), .rst_n(rst_n),
    .acc_start(acc_start), .acc_we(acc_we), .acc_reg(acc_reg),
    .acc_dev(acc_dev), .acc_wdata(acc_wdata),
    .acc_done(acc_done), .acc_rdata(acc_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .page_phase(page_phase), .data_phase(data_phase)
  );

  sdx_gap_timer #(.CYC(POLL_CYCLES)) u_gap (
    .clk(clk), .rst_n(rst_n), .arm(gap_arm), .gap_busy(gap_busy)
  );
endmodule

// File: rtl/sdx_seq_checker.sv
module sdx_seq_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [DW-1:0] rsp_rdata,
  input logic          bus_req,
  input logic          bus_we,
  input logic [11:0]   bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic          page_phase,
  input logic          data_phase
);
  AST_PAGE_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    page_phase && bus_ready |=> data_phase && bus_req);                         // R1
  AST_PAGE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    page_phase |-> bus_we && bus_addr == 12'h800 && bus_wdata[6:0] == 7'h40);   // R1
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> (bus_addr == 12'h280 || bus_addr == 12'h284 || bus_addr == 12'h288)); // R2
  AST_KICK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase && bus_we && bus_addr == 12'h280 |-> (bus_wdata == 16'h0001 || bus_wdata == 16'h0003)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);                                                    // R6
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);                                                    // R7
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)); // R9
  AST_RDATA_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done);                                          // R10
endmodule

bind sdx_paged_seq sdx_seq_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .rsp_rdata(rsp_rdata), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .page_phase(page_phase), .data_phase(data_phase)
);

// File: tb/sdx_paged_seq_tb.sv
module sdx_paged_seq_tb;
  localparam int POLL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [4:0]  req_dev = '0;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic bus_ready = 1'b0;

  always #10 clk = ~clk;

  sdx_paged_seq #(.DW(16), .POLL_CYCLES(POLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_dev(req_dev), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // window model state
  int cyc = 0;
  int busy_cnt = 0, busy_delay = 3;
  logic [15:0] m_page = '0, m_adr = '0, m_dat = '0;
  bit page_seen = 0, gap_pend = 0;
  int gap_ref = 0;
  logic [15:0] m_mem [logic [15:0]];
  logic [4:0] cur_dev = '0;
  int tok [32];
  logic [15:0] twd [32];
  int log_n = 0;

  function automatic logic [15:0] dflt(input logic [15:0] a);
    return a ^ 16'h5a3c;
  endfunction
  function automatic logic [15:0] want_page(input logic [4:0] d);
    return 16'(int'(d) * 128 + int'(16'h80a0) / 512);
  endfunction

  task automatic put_tok(input int t, input logic [15:0] w);
    if (t == 0 && log_n > 0 && tok[log_n-1] == 0) return;
    if (log_n < 32) begin tok[log_n] = t; twd[log_n] = w; log_n++; end
  endtask

  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (busy_cnt != 0) busy_cnt--;
    if (!rst_n) begin
      bus_ready = 1'b0;
    end else begin
      rdy = ($urandom % 3) != 0;
      bus_ready = rdy;
      if (bus_req && rdy) begin
        if (bus_addr == 12'h800) begin
          chk(bus_we, "R1 page access is a write", bus_we, 1);
          m_page = bus_wdata; page_seen = 1;
          if (gap_pend) begin
            chk(cyc - gap_ref > POLL, "R5 idle gap after busy poll", cyc - gap_ref, POLL + 1);
            gap_pend = 0;
          end
        end else begin
          chk(page_seen && m_page == want_page(cur_dev), "R1 page before data access",
              m_page, want_page(cur_dev));
          page_seen = 0;
          if (bus_addr != 12'h280)
            chk(busy_cnt == 0, "R3 register touched while busy", busy_cnt, 0);
          case ({bus_we, bus_addr})
            {1'b0, 12'h280}: begin
              bus_rdata = {15'd0, busy_cnt != 0};
              if (busy_cnt != 0) begin gap_pend = 1; gap_ref = cyc; end
              put_tok(0, 0);
            end
            {1'b1, 12'h284}: begin m_adr = bus_wdata; put_tok(1, bus_wdata); end
            {1'b1, 12'h288}: begin m_dat = bus_wdata; put_tok(2, bus_wdata); end
            {1'b1, 12'h280}: begin
              put_tok(3, bus_wdata);
              busy_cnt = busy_delay;
              if (bus_wdata[1]) m_mem[m_adr] = m_dat;
              else m_dat = m_mem.exists(m_adr) ? m_mem[m_adr] : dflt(m_adr);
            end
            {1'b0, 12'h288}: begin bus_rdata = m_dat; put_tok(4, 0); end
            default: chk(0, "R2 window offset", bus_addr, 12'h280);
          endcase
        end
      end
    end
  end

  // one-cycle done pulse monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && prev_done && rsp_done) chk(0, "R6 done wider than one cycle", 1, 0);
    prev_done = rsp_done;
  end

  logic [15:0] shadow [logic [15:0]];

  task automatic run_op(input bit wr, input logic [15:0] a, input logic [4:0] d,
                        input logic [15:0] wd, input bit inject, input bit chain);
    logic [15:0] exp_rd;
    int ex_t [5];
    logic [15:0] ex_w [5];
    int ex_n, wait_n;
    cur_dev = d; log_n = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_dev = d; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, chain ? "R7 request in done cycle taken" : "R7 request taken",
        req_ready, 0);
    wait_n = 0;
    while (!rsp_done && wait_n < 3000) begin
      if (wait_n == 2 && inject) begin
        chk(req_ready == 0, "R7 ready low during sequence", req_ready, 0);
        req_valid = 1; req_write = ~wr; req_addr = ~a; req_dev = ~d; req_wdata = ~wd;
      end
      if (wait_n == 3) req_valid = 0;
      @(negedge clk);
      wait_n++;
    end
    if (wr) begin
      ex_n = 4;
      ex_t = '{0, 1, 2, 3, 0}; ex_w = '{16'h0, a, wd, 16'h3, 16'h0};
      shadow[a] = wd;
    end else begin
      ex_n = 5;
      ex_t = '{0, 1, 3, 0, 4}; ex_w = '{16'h0, a, 16'h1, 16'h0, 16'h0};
      exp_rd = shadow.exists(a) ? shadow[a] : dflt(a);
      chk(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
    end
    chk(log_n == ex_n, wr ? "R4 write step count" : "R3 read step count", log_n, ex_n);
    for (int i = 0; i < ex_n && i < log_n; i++) begin
      chk(tok[i] == ex_t[i] && twd[i] == ex_w[i], wr ? "R4 write step" : "R3 read step",
          tok[i] * 65536 + int'(twd[i]), ex_t[i] * 65536 + int'(ex_w[i]));
    end
    if (!chain) begin
      for (int i = 0; i < 4; i++) @(negedge clk);
      chk(log_n == ex_n && !bus_req && req_ready, "R7 no activity after done",
          log_n, ex_n);
    end
  endtask

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !bus_req && !bus_we && !rsp_done && rsp_rdata == 0,
        "R8 reset state", {req_ready, bus_req, bus_we, rsp_done}, 4'b1000);
    // directed: corner addresses and devices
    busy_delay = 0;
    run_op(1, 16'hffff, 5'd31, 16'hbeef, 0, 0);
    run_op(0, 16'hffff, 5'd31, 16'h0, 0, 0);
    run_op(0, 16'h0000, 5'd0, 16'h0, 0, 0);
    // busy flag still set from a write: forces repeated polls
    busy_delay = 25;
    run_op(1, 16'h1234, 5'd9, 16'h55aa, 0, 1);
    run_op(0, 16'h1234, 5'd9, 16'h0, 0, 0);
    // request in the middle of a sequence is ignored
    run_op(0, 16'h2a2a, 5'd4, 16'h0, 1, 0);
    run_op(1, 16'h0777, 5'd17, 16'h0101, 1, 0);
    // random mix, sometimes chained on the done cycle
    for (int n = 0; n < 60; n++) begin
      busy_delay = $urandom % 16;
      run_op($urandom % 2, 16'($urandom % 64) ^ 16'h8c00, 5'($urandom), 16'($urandom),
             ($urandom % 4) == 0, ($urandom % 3) == 0);
    end
    for (int i = 0; i < 6; i++) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R6 actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule